// File: doc/BRIEF.md
# One-Bit Noise-Shaping Modulator

This block turns multi-bit PCM, already oversampled to eight times the audio rate, into a one-bit stream at 384 times the audio rate. Each channel holds its current sample for 48 master clocks. During that time a second-order noise-shaping loop runs at the master clock rate. The loop moves quantization noise out of the audio band. The mean of the bitstream follows the held sample.

Each channel drives a pair of output bits. The two bits are always complements, so an external differential amplifier and low-pass filter can recover the analog signal. A new sample is accepted only on the update slot, which repeats every 48 clocks, and only when that channel's valid strobe is high. While reset is held, every output pair carries a pattern that alternates on every clock. That pattern averages to analog zero.

Top module: `sdm_onebit_mod`

## Requirements
- R1: While `rst_n` is low, every `dac_pos` bit toggles on every rising clock edge. The matching `dac_neg` bit is its complement, starting one clock after reset is asserted.
- R2: Starting one clock after reset is first asserted, `dac_neg[c]` equals the inverse of `dac_pos[c]` at every clock edge, in reset and in normal operation.
- R3: For a held two's-complement sample `x` of `DW` bits, the fraction of ones on `dac_pos` over a long window is `(1 + x / 2^(DW-1)) / 2`. For |x| up to half scale it lies within 8 counts of that value per 960 clocks.
- R4: When a channel's `pcm_vld` bit is low, that channel ignores its `pcm_in` field. The previously accepted sample stays in force.
- R5: Update slots occur every 48 clocks. The first slot is the 50th rising edge after `rst_n` rises, which allows for two edges of reset synchronization. A valid pulse that falls on any other edge is ignored.
- R6: Both loop integrators are 28 bits wide and clamp at their signed limits instead of wrapping. A full-scale positive input gives at least 950 ones per 960 clocks. A full-scale negative input gives at most 10.
- R7: Reset clears the held samples and the loop state to zero. After reset is released, and with no valid pulse, each channel produces the zero-input density of 480 ± 8 ones per 960 clocks, even if a non-zero sample was held before reset.
- R8: Channels are independent. Channel `c` uses bits `[c*DW +: DW]` of `pcm_in` and bit `c` of `pcm_vld`, `dac_pos` and `dac_neg`, and different samples on different channels give their own densities at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, 384 times the audio sample rate |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| pcm_in | input | NCH*DW | Packed signed samples at eight times the audio rate, channel c in bits [c*DW +: DW] |
| pcm_vld | input | NCH | Per-channel valid strobe, sampled on the update slot |
| dac_pos | output | NCH | Positive bitstream per channel |
| dac_neg | output | NCH | Complement bitstream per channel |

## Verification
The embedded properties check these rules on every clock:
- the two output bits are complements;
- the output toggles on every edge while reset holds;
- a held sample changes only on an update slot;
- update slots are exactly 48 clocks apart;
- the first integrator never jumps from one signed extreme to the other, which a wrapping adder would do under full-scale drive.

Only the bench scenarios show that the bitstream density tracks the sample value. They also show that strobes off the slot are ignored, that clamping keeps full-scale input near all ones or all zeros, and that a mid-run reset brings the output back to the zero-input density.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

  localparam int unsigned SDM_DW_DEF    = 24;
  localparam int unsigned SDM_IW_DEF    = 28;
  localparam int unsigned SDM_RATIO_DEF = 48;
  localparam int unsigned SDM_NCH_DEF   = 2;
  localparam int unsigned SDM_SYNC_DEF  = 2;

  typedef struct packed {
    logic pos;
    logic neg;
  } bit_pair_t;

endpackage

// File: rtl/sdm_rst_sync.sv
module sdm_rst_sync #(
  parameter int unsigned STAGES = sdm_pkg::SDM_SYNC_DEF
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_core_n = chain_q[STAGES-1];

endmodule

// File: rtl/sdm_rate_gen.sv
module sdm_rate_gen #(
  parameter int unsigned RATIO = sdm_pkg::SDM_RATIO_DEF
) (
  input  logic clk,
  input  logic rst_core_n,
  output logic load_stb
);

  localparam int unsigned PW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(RATIO - 1);

  logic [PW-1:0] phase_q;
  logic [PW-1:0] phase_d;
  logic          wrap;

  always_comb begin
    wrap    = (phase_q == PH_LAST);
    phase_d = wrap ? '0 : phase_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) phase_q <= '0;
    else             phase_q <= phase_d;
  end

  assign load_stb = wrap;

endmodule

// File: rtl/sdm_shaper.sv
module sdm_shaper #(
  parameter int unsigned DW = sdm_pkg::SDM_DW_DEF,
  parameter int unsigned IW = sdm_pkg::SDM_IW_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rst_core_n,
  input  logic          load_stb,
  input  logic [DW-1:0] pcm,
  input  logic          vld,
  output logic          bit_pos,
  output logic          bit_neg
);

  localparam int unsigned SW = IW + 2;
  localparam logic signed [SW-1:0] ACC_MAX = {3'b000, {(IW-1){1'b1}}};
  localparam logic signed [SW-1:0] ACC_MIN = {3'b111, {(IW-1){1'b0}}};
  localparam logic signed [SW-1:0] FB_POS  = {{(SW-DW){1'b0}}, 1'b1, {(DW-1){1'b0}}};

  // held sample
  logic [DW-1:0] hold_q;
  logic [DW-1:0] hold_d;
  logic          hold_en;

  // loop state
  logic [IW-1:0] i1_q, i1_d;
  logic [IW-1:0] i2_q, i2_d;

  logic signed [SW-1:0] x_ext;
  logic signed [SW-1:0] fb;
  logic signed [SW-1:0] sum1;
  logic signed [SW-1:0] sum2;
  logic                 q_now;

  sdm_pkg::bit_pair_t out_q;
  sdm_pkg::bit_pair_t out_d;

  function automatic logic [IW-1:0] clamp(input logic signed [SW-1:0] v);
    if (v > ACC_MAX)      clamp = ACC_MAX[IW-1:0];
    else if (v < ACC_MIN) clamp = ACC_MIN[IW-1:0];
    else                  clamp = v[IW-1:0];
  endfunction

  // sample hold: written only on an update slot with valid high
  always_comb begin
    hold_en = load_stb & vld;
    hold_d  = hold_en ? pcm : hold_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) hold_q <= '0;
    else             hold_q <= hold_d;
  end

  // second-order loop, delaying integrators, feedback gains 1 and 2
  always_comb begin
    x_ext = {{(SW-DW){hold_q[DW-1]}}, hold_q};
    q_now = ~i2_q[IW-1];
    fb    = q_now ? FB_POS : -FB_POS;
    sum1  = {{2{i1_q[IW-1]}}, i1_q} + x_ext - fb;
    sum2  = {{2{i2_q[IW-1]}}, i2_q} + {{2{i1_q[IW-1]}}, i1_q} - (fb <<< 1);
    i1_d  = clamp(sum1);
    i2_d  = clamp(sum2);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      i1_q <= '0;
      i2_q <= '0;
    end else begin
      i1_q <= i1_d;
      i2_q <= i2_d;
    end
  end

  // output pair: quantizer in run, alternating zero pattern in reset
  always_comb begin
    if (rst_core_n) begin
      out_d.pos = q_now;
      out_d.neg = ~q_now;
    end else begin
      out_d.pos = ~out_q.pos;
      out_d.neg = out_q.pos;
    end
  end

  always_ff @(posedge clk) begin
    out_q <= out_d;
  end

  assign bit_pos = out_q.pos;
  assign bit_neg = out_q.neg;

  // R2: pair stays complementary
  assert_pair_complement_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_neg == ~bit_pos);

  // R1: alternating pattern while reset holds
  assert_reset_toggle_R1: assert property (@(posedge clk) disable iff (rst_core_n)
    !rst_core_n |=> (bit_pos != $past(bit_pos)));

  // R4: sample changes only on a slot with valid
  assert_hold_between_slots_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(load_stb && vld) |=> $stable(hold_q));

  // R6: first integrator never wraps between signed extremes
  assert_no_wrap_hi_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (i1_q[IW-1:IW-2] == 2'b01) |=> (i1_q[IW-1:IW-2] != 2'b10));
  assert_no_wrap_lo_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (i1_q[IW-1:IW-2] == 2'b10) |=> (i1_q[IW-1:IW-2] != 2'b01));

endmodule

// File: rtl/sdm_onebit_mod.sv
module sdm_onebit_mod #(
  parameter int unsigned NCH   = sdm_pkg::SDM_NCH_DEF,
  parameter int unsigned DW    = sdm_pkg::SDM_DW_DEF,
  parameter int unsigned IW    = sdm_pkg::SDM_IW_DEF,
  parameter int unsigned RATIO = sdm_pkg::SDM_RATIO_DEF,
  parameter int unsigned SYNC  = sdm_pkg::SDM_SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH*DW-1:0] pcm_in,
  input  logic [NCH-1:0]    pcm_vld,
  output logic [NCH-1:0]    dac_pos,
  output logic [NCH-1:0]    dac_neg
);

  localparam int unsigned GW = $clog2(RATIO) + 1;

  logic rst_core_n;
  logic load_stb;

  sdm_rst_sync #(.STAGES(SYNC)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  sdm_rate_gen #(.RATIO(RATIO)) u_rate_gen (
    .clk        (clk),
    .rst_core_n (rst_core_n),
    .load_stb   (load_stb)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    sdm_shaper #(.DW(DW), .IW(IW)) u_shaper (
      .clk        (clk),
      .rst_n      (rst_n),
      .rst_core_n (rst_core_n),
      .load_stb   (load_stb),
      .pcm        (pcm_in[c*DW +: DW]),
      .vld        (pcm_vld[c]),
      .bit_pos    (dac_pos[c]),
      .bit_neg    (dac_neg[c])
    );
  end

  // slot spacing checker
  logic [GW-1:0] gap_q;
  logic          seen_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      gap_q  <= load_stb ? '0 : gap_q + GW'(1);
      seen_q <= seen_q | load_stb;
    end
  end

  assert_slot_spacing_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (load_stb && seen_q) |-> (gap_q == GW'(RATIO - 1)));

endmodule

// File: tb/sdm_onebit_mod_bench.sv
module sdm_onebit_mod_bench;

  localparam int NCH = 2;
  localparam int DW  = 24;
  localparam int FS  = 1 << (DW - 1);
  localparam int WIN = 960;
  localparam int TOL = 8;

  logic              clk;
  logic              rst_n;
  logic [NCH*DW-1:0] pcm_in;
  logic [NCH-1:0]    pcm_vld;
  logic [NCH-1:0]    dac_pos;
  logic [NCH-1:0]    dac_neg;

  int n_run;
  int n_fail;
  int cyc;

  sdm_onebit_mod u_sdm_onebit_mod (
    .clk     (clk),
    .rst_n   (rst_n),
    .pcm_in  (pcm_in),
    .pcm_vld (pcm_vld),
    .dac_pos (dac_pos),
    .dac_neg (dac_neg)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_pcm(input int ch, input int val);
    pcm_in[ch*DW +: DW] = DW'(val);
  endtask

  function automatic int expect_ones(input int val);
    return (WIN / 2) + ((WIN / 2) * val) / FS;
  endfunction

  // count ones per channel over a window, checking complement on the way (R2)
  task automatic measure(input int settle, output int ones0, output int ones1);
    int bad;
    bad = 0;
    ones0 = 0;
    ones1 = 0;
    repeat (settle) @(negedge clk);
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      ones0 += int'(dac_pos[0]);
      ones1 += int'(dac_pos[1]);
      if (dac_neg != ~dac_pos) bad++;
    end
    check(bad == 0, "R2 complement during run", bad, 0);
  endtask

  task automatic check_density(input string req, input int act, input int exp);
    check((act >= exp - TOL) && (act <= exp + TOL), req, act, exp);
  endtask

  task automatic t_reset_pattern;
    int bad;
    logic [NCH-1:0] prev;
    bad = 0;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    prev = dac_pos;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (dac_pos != ~prev) bad++;
      if (dac_neg != ~dac_pos) bad++;
      prev = dac_pos;
    end
    check(bad == 0, "R1 alternating pattern in reset", bad, 0);
  endtask

  task automatic release_reset;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_zero_idle;
    int o0, o1;
    measure(192, o0, o1);
    check_density("R7 ch0 zero density after reset", o0, expect_ones(0));
    check_density("R7 ch1 zero density after reset", o1, expect_ones(0));
  endtask

  task automatic t_levels;
    int o0, o1;
    set_pcm(0, FS / 4);
    set_pcm(1, -FS / 2);
    pcm_vld = 2'b11;
    measure(192, o0, o1);
    check_density("R3 ch0 quarter scale", o0, expect_ones(FS / 4));
    check_density("R8 ch1 independent negative half", o1, expect_ones(-FS / 2));
    set_pcm(0, -FS / 2);
    set_pcm(1, FS / 2);
    measure(192, o0, o1);
    check_density("R3 ch0 negative half", o0, expect_ones(-FS / 2));
    check_density("R8 ch1 positive half", o1, expect_ones(FS / 2));
  endtask

  task automatic t_hold;
    int o0, o1;
    set_pcm(0, FS / 4);
    set_pcm(1, 0);
    measure(192, o0, o1);
    @(negedge clk);
    pcm_vld = 2'b00;
    set_pcm(0, -FS / 2);
    set_pcm(1, FS / 2);
    measure(192, o0, o1);
    check_density("R4 ch0 held with valid low", o0, expect_ones(FS / 4));
    check_density("R4 ch1 held with valid low", o1, expect_ones(0));
  endtask

  task automatic t_slot;
    int o0, o1;
    // pulse away from the slot: ignored
    while ((cyc % 48) != 20) @(negedge clk);
    set_pcm(0, FS / 2);
    pcm_vld = 2'b01;
    @(negedge clk);
    pcm_vld = 2'b00;
    measure(192, o0, o1);
    check_density("R5 off-slot pulse ignored", o0, expect_ones(FS / 4));
    // pulse on the slot edge: accepted
    while ((cyc % 48) != 1) @(negedge clk);
    pcm_vld = 2'b01;
    @(negedge clk);
    pcm_vld = 2'b00;
    set_pcm(0, 0);
    measure(192, o0, o1);
    check_density("R5 on-slot pulse accepted", o0, expect_ones(FS / 2));
  endtask

  task automatic t_full;
    int o0, o1;
    set_pcm(0, FS - 1);
    set_pcm(1, -FS);
    pcm_vld = 2'b11;
    measure(192, o0, o1);
    check(o0 >= 950, "R6 positive full scale", o0, 950);
    check(o1 <= 10, "R6 negative full scale", o1, 10);
  endtask

  task automatic t_midreset;
    set_pcm(0, FS / 2);
    set_pcm(1, -FS / 2);
    pcm_vld = 2'b11;
    repeat (200) @(negedge clk);
    pcm_vld = 2'b00;
    t_reset_pattern();
    release_reset();
    t_zero_idle();
  endtask

  initial begin
    #(20 * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run   = 0;
    n_fail  = 0;
    rst_n   = 1'b1;
    pcm_in  = '0;
    pcm_vld = '0;
    #1 rst_n = 1'b0;
    t_reset_pattern();
    release_reset();
    t_zero_idle();
    t_levels();
    t_hold();
    t_slot();
    t_full();
    t_midreset();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule